// File: doc/BRIEF.md
# Chained MAC Return-Address Authenticator

This unit guards function returns without keeping a shadow stack in protected memory. It holds two private registers: a secret key and a "top" tag. On every call, the current top tag is handed out so that software can push it onto the ordinary stack beside the return address. The top register then takes a keyed MAC of the old top tag and the return address. Each tag therefore depends on every tag before it, so only the top register needs protection. All older tags can live in memory an attacker can reach.

On a return, the caller supplies the return address and the tag it popped from the stack. The unit recomputes the MAC from those two values and compares the result with the top register, all in the same cycle. If they match, the popped tag becomes the new top and the return is approved. If they differ, the return is rejected and a sticky fault is raised. A start pulse seeds both private registers with fresh random values when a new process begins. Software has no other way to read or write either register.

Top module: `ret_chain_auth`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, push_tag_o, ret_ok_o, ret_fail_o and fault_o are all 0, and the unit is not armed.
- R2: A start_i pulse loads the top register from seed_top_i and the key from seed_key_i at the clock edge. It also arms the unit and clears fault_o. If call_i or ret_i is high in the same cycle, start_i takes priority and the call or return has no effect.
- R3: Until the first start_i, call_i and ret_i are ignored: push_tag_o stays 0, ret_ok_o and ret_fail_o stay 0, and no state changes.
- R4: During an accepted call, push_tag_o equals the current top value in the same cycle. In every other cycle push_tag_o is 0.
- R5: An accepted call replaces the top register at the clock edge with MAC(old top, ret_addr_i).
- R6: The MAC is defined as follows, for width W, ROUNDS rounds, all sums mod 2^W, and rotl a left rotate. Start with a0 = previous tag and b0 = return address. For each round i, a(i+1) = rotl(a(i) xor b(i), 7) + (rotl(key, (3i+1) mod W) xor i), and b(i+1) = b(i) + rotl(a(i+1), 11). The tag is a(ROUNDS) xor b(ROUNDS). Calls and returns use the same function.
- R7: During an accepted return, ret_ok_o is 1 in the same cycle when MAC(prev_tag_i, ret_addr_i) equals the top register. The top register then takes prev_tag_i at the clock edge.
- R8: If the recomputed MAC does not match, ret_fail_o is 1 for that cycle, the top register is left unchanged, and fault_o becomes 1 at the next edge. fault_o then stays 1 until the next start_i.
- R9: If call_i and ret_i are both high in the same cycle, no operation takes place: push_tag_o is 0, ret_ok_o and ret_fail_o are 0, and the top register is unchanged.
- R10: The top register changes only on start, on an accepted call, or on a matching return. Idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | New-process pulse that loads the seeds |
| seed_top_i | input | W | Random initial value for the top register |
| seed_key_i | input | W | Random secret key |
| call_i | input | 1 | Call request |
| ret_i | input | 1 | Return request |
| ret_addr_i | input | W | Return address of the call or return |
| prev_tag_i | input | W | Tag popped from the memory stack on a return |
| push_tag_o | output | W | Tag to push on a call |
| ret_ok_o | output | 1 | Return approved (same cycle) |
| ret_fail_o | output | 1 | Return rejected (same cycle) |
| fault_o | output | 1 | Sticky authentication fault |

## Verification
The bench drives deep call chains with addresses built by arithmetic and unwinds them in reverse. A correct unwind approves every return and brings the pushed tag back to the seed, which tells a working chain apart from a broken MAC or a broken restore. A single-bit change to an address, a forged popped tag, and a tag computed under an earlier key each cause a rejection, and the bench then confirms that the correct return still passes. These cases separate a fault from a corrupted top register. Calls before seeding, simultaneous call and return, and a start coinciding with a call are each checked at the pushed tag, which shows whether the top register was touched.

// File: rtl/rca_pkg.sv
package rca_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_SEED = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } rca_op_e;

  localparam int unsigned ROT_MIX  = 7;
  localparam int unsigned ROT_FEED = 11;
  localparam int unsigned RK_STEP  = 3;
endpackage

// File: rtl/rca_decode.sv
module rca_decode
  import rca_pkg::*;
(
  input  logic    start_i,
  input  logic    call_i,
  input  logic    ret_i,
  input  logic    armed_i,
  output rca_op_e op_o
);
  always_comb begin
    op_o = OP_IDLE;
    if (start_i)                  op_o = OP_SEED;
    else if (!armed_i)            op_o = OP_IDLE;
    else if (call_i && !ret_i)    op_o = OP_CALL;
    else if (ret_i && !call_i)    op_o = OP_RET;
  end
endmodule

// File: rtl/rca_mac.sv
module rca_mac
  import rca_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ROUNDS = 4
) (
  input  logic [W-1:0] key_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] addr_i,
  output logic [W-1:0] tag_o
);
  localparam int unsigned RM = ROT_MIX % W;
  localparam int unsigned RF = ROT_FEED % W;

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int unsigned n);
    return (x << n) | (x >> (W - n));
  endfunction

  logic [W-1:0] a_s [ROUNDS+1];
  logic [W-1:0] b_s [ROUNDS+1];

  assign a_s[0] = prev_i;
  assign b_s[0] = addr_i;

  for (genvar r = 0; r < ROUNDS; r++) begin : g_round
    localparam int unsigned RK_ROT = (RK_STEP * r + 1) % W;
    logic [W-1:0] rk;
    assign rk         = rotl(key_i, RK_ROT) ^ W'(r);
    assign a_s[r+1]   = rotl(a_s[r] ^ b_s[r], RM) + rk;
    assign b_s[r+1]   = b_s[r] + rotl(a_s[r+1], RF);
  end

  assign tag_o = a_s[ROUNDS] ^ b_s[ROUNDS];
endmodule

// File: rtl/rca_state.sv
module rca_state
  import rca_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  rca_op_e      op_i,
  input  logic [W-1:0] seed_top_i,
  input  logic [W-1:0] seed_key_i,
  input  logic [W-1:0] mac_i,
  input  logic [W-1:0] prev_tag_i,
  input  logic         match_i,
  output logic [W-1:0] top_o,
  output logic [W-1:0] key_o,
  output logic         armed_o,
  output logic         fault_o
);
  logic [W-1:0] top_d;
  logic         fault_d;

  always_comb begin
    top_d   = top_o;
    fault_d = fault_o;
    unique case (op_i)
      OP_SEED: begin
        top_d   = seed_top_i;
        fault_d = 1'b0;
      end
      OP_CALL: top_d = mac_i;
      OP_RET: begin
        if (match_i) top_d   = prev_tag_i;
        else         fault_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_o   <= '0;
      key_o   <= '0;
      armed_o <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      top_o   <= top_d;
      fault_o <= fault_d;
      if (op_i == OP_SEED) begin
        key_o   <= seed_key_i;
        armed_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ret_chain_auth.sv
module ret_chain_auth
  import rca_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ROUNDS = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] seed_top_i,
  input  logic [W-1:0] seed_key_i,
  input  logic         call_i,
  input  logic         ret_i,
  input  logic [W-1:0] ret_addr_i,
  input  logic [W-1:0] prev_tag_i,
  output logic [W-1:0] push_tag_o,
  output logic         ret_ok_o,
  output logic         ret_fail_o,
  output logic         fault_o
);
  rca_op_e      op;
  logic [W-1:0] top_q;
  logic [W-1:0] key_q;
  logic         armed_q;
  logic [W-1:0] mac_prev;
  logic [W-1:0] mac_tag;
  logic         match;

  rca_decode u_decode (
    .start_i (start_i),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .armed_i (armed_q),
    .op_o    (op)
  );

  // one MAC shared by call and return
  assign mac_prev = (op == OP_RET) ? prev_tag_i : top_q;

  rca_mac #(.W(W), .ROUNDS(ROUNDS)) u_mac (
    .key_i  (key_q),
    .prev_i (mac_prev),
    .addr_i (ret_addr_i),
    .tag_o  (mac_tag)
  );

  assign match = (mac_tag == top_q);

  rca_state #(.W(W)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .seed_top_i (seed_top_i),
    .seed_key_i (seed_key_i),
    .mac_i      (mac_tag),
    .prev_tag_i (prev_tag_i),
    .match_i    (match),
    .top_o      (top_q),
    .key_o      (key_q),
    .armed_o    (armed_q),
    .fault_o    (fault_o)
  );

  assign push_tag_o = (op == OP_CALL) ? top_q : '0;
  assign ret_ok_o   = (op == OP_RET) && match;
  assign ret_fail_o = (op == OP_RET) && !match;
endmodule

// File: rtl/rca_chk.sv
module rca_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         call_i,
  input logic         ret_i,
  input logic [W-1:0] seed_top_i,
  input logic [W-1:0] prev_tag_i,
  input logic [W-1:0] push_tag_o,
  input logic         ret_ok_o,
  input logic         ret_fail_o,
  input logic         fault_o,
  input logic [W-1:0] top_q,
  input logic         armed_q
);
  // R2
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> armed_q && !fault_o && top_q == $past(seed_top_i));

  // R3
  unarmed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> push_tag_o == '0 && !ret_ok_o && !ret_fail_o);

  // R4
  push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && call_i && !ret_i && !start_i) |-> push_tag_o == top_q);

  // R7
  ret_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_ok_o && !start_i) |=> top_q == $past(prev_tag_i));

  // R8
  fail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_fail_o && !start_i) |=> fault_o && top_q == $past(top_q));

  // R8
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !start_i) |=> fault_o);

  // R9
  both_noop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && ret_i && !start_i) |=> top_q == $past(top_q));

  // R10
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !call_i && !ret_i) |=> $stable(top_q));

  // R7
  verdict_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ret_ok_o && ret_fail_o));
endmodule

bind ret_chain_auth rca_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .call_i     (call_i),
  .ret_i      (ret_i),
  .seed_top_i (seed_top_i),
  .prev_tag_i (prev_tag_i),
  .push_tag_o (push_tag_o),
  .ret_ok_o   (ret_ok_o),
  .ret_fail_o (ret_fail_o),
  .fault_o    (fault_o),
  .top_q      (top_q),
  .armed_q    (armed_q)
);

// File: tb/tb_ret_chain_auth.sv
module tb_ret_chain_auth;
  localparam int unsigned W      = 32;
  localparam int unsigned ROUNDS = 4;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned DEPTH  = 40;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] seed_top_i = '0;
  logic [W-1:0] seed_key_i = '0;
  logic         call_i = 1'b0;
  logic         ret_i = 1'b0;
  logic [W-1:0] ret_addr_i = '0;
  logic [W-1:0] prev_tag_i = '0;
  logic [W-1:0] push_tag_o;
  logic         ret_ok_o;
  logic         ret_fail_o;
  logic         fault_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] c_push;
  logic         c_ok, c_fail;
  logic [W-1:0] m_top, m_key;
  logic [W-1:0] st_tag  [DEPTH];
  logic [W-1:0] st_addr [DEPTH];

  always #(PERIOD/2) clk_i = ~clk_i;

  ret_chain_auth #(.W(W), .ROUNDS(ROUNDS)) dut (.*);

  function automatic logic [W-1:0] rl(input logic [W-1:0] x, input int unsigned n);
    return (n == 0) ? x : ((x << n) | (x >> (W - n)));
  endfunction

  function automatic logic [W-1:0] mac(input logic [W-1:0] k, p, a);
    logic [W-1:0] x = p, y = a;
    for (int i = 0; i < ROUNDS; i++) begin
      x = rl(x ^ y, 7) + (rl(k, (3 * i + 1) % W) ^ W'(i));
      y = y + rl(x, 11);
    end
    return x ^ y;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, r, s, input logic [W-1:0] a, p, st, sk);
    @(negedge clk_i);
    call_i = c; ret_i = r; start_i = s;
    ret_addr_i = a; prev_tag_i = p; seed_top_i = st; seed_key_i = sk;
    #(PERIOD/4);
    c_push = push_tag_o; c_ok = ret_ok_o; c_fail = ret_fail_o;
    @(posedge clk_i);
    #1;
    call_i = 0; ret_i = 0; start_i = 0;
  endtask

  task automatic do_call(input logic [W-1:0] a, input string req);
    step(1, 0, 0, a, '0, '0, '0);
    chk(c_push == m_top, req, c_push, m_top);
    m_top = mac(m_key, m_top, a);
  endtask

  task automatic do_ret_ok(input logic [W-1:0] a, p, input string req);
    step(0, 1, 0, a, p, '0, '0);
    chk(c_ok && !c_fail, req, {30'd0, c_fail, c_ok}, 32'd1);
    m_top = p;
  endtask

  task automatic do_ret_bad(input logic [W-1:0] a, p, input string req);
    step(0, 1, 0, a, p, '0, '0);
    chk(!c_ok && c_fail, req, {30'd0, c_fail, c_ok}, 32'd2);
    chk(fault_o == 1'b1, req, W'(fault_o), 32'd1);
  endtask

  task automatic run_chain(input int depth, input logic [W-1:0] base, input string req);
    for (int i = 0; i < depth; i++) begin
      st_tag[i]  = m_top;
      st_addr[i] = base + W'(i * 32'h0000_0104) ^ W'(i << 20);
      do_call(st_addr[i], req);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] old_key;
    m_top = '0; m_key = '0;
    #(PERIOD * 2 + 3);
    // R1
    chk(push_tag_o == '0 && !ret_ok_o && !ret_fail_o && !fault_o, "R1",
        {push_tag_o[W-4:0], ret_ok_o, ret_fail_o, fault_o}, '0);
    rst_ni = 1'b1;
    // R1 / R3: unarmed requests ignored
    step(1, 0, 0, 32'h1000, '0, '0, '0);
    chk(c_push == '0, "R3 call before seed", c_push, '0);
    step(0, 1, 0, 32'h1000, '0, '0, '0);
    chk(!c_ok && !c_fail, "R3 ret before seed", {30'd0, c_fail, c_ok}, '0);
    chk(!fault_o, "R1 fault after reset", W'(fault_o), '0);

    // R2: start with coincident call, start wins
    step(1, 0, 1, 32'h2222, '0, 32'hA5A5_0F0F, 32'h1357_9BDF);
    chk(c_push == '0, "R2 start beats call", c_push, '0);
    m_top = 32'hA5A5_0F0F; m_key = 32'h1357_9BDF;
    do_call(32'h0800_0010, "R2 top seeded");
    do_ret_ok(32'h0800_0010, 32'hA5A5_0F0F, "R7 single");

    // R5 R6 R4: deep chain
    run_chain(DEPTH, 32'h0800_4000, "R5");
    // R8 tampered address at depth
    do_ret_bad(st_addr[DEPTH-1] ^ 32'h1, st_tag[DEPTH-1], "R8 addr bit flip");
    do_ret_bad(st_addr[DEPTH-1], st_tag[DEPTH-1] ^ 32'h8000_0000, "R8 forged tag");
    // R9 both high with valid data
    step(1, 1, 0, st_addr[DEPTH-1], st_tag[DEPTH-1], '0, '0);
    chk(!c_ok && !c_fail && c_push == '0, "R9 call+ret", c_push, '0);
    // R10 idle cycles
    for (int i = 0; i < 5; i++) step(0, 0, 0, 32'hFFFF_FFFF, 32'h1234, '0, '0);
    // R7 unwind; top unchanged by failures/no-ops (R8 R9 R10)
    for (int i = DEPTH - 1; i >= 0; i--)
      do_ret_ok(st_addr[i], st_tag[i], "R7 unwind");
    chk(fault_o == 1'b1, "R8 fault sticky", W'(fault_o), 32'd1);
    do_call(32'h0, "R7 back to seed");
    chk(c_push == 32'hA5A5_0F0F, "R7 seed restored", c_push, 32'hA5A5_0F0F);

    // R2: reseed clears fault; old-key tag rejected (R6)
    old_key = m_key;
    step(0, 0, 1, '0, '0, 32'h0BAD_F00D, 32'hC0DE_0001);
    chk(!fault_o, "R2 fault cleared", W'(fault_o), '0);
    m_top = 32'h0BAD_F00D; m_key = 32'hC0DE_0001;
    run_chain(24, 32'h0001_0000, "R6 second key");
    // a forged top under the old key: the tag whose MAC under old key would match
    step(0, 1, 0, st_addr[23], mac(old_key, st_tag[23], st_addr[23]), '0, '0);
    chk(!c_ok && c_fail, "R8 old key forgery", {30'd0, c_fail, c_ok}, 32'd2);
    for (int i = 23; i >= 0; i--)
      do_ret_ok(st_addr[i], st_tag[i], "R7 second unwind");
    do_call(32'h44, "R10 top after second unwind");
    chk(c_push == 32'h0BAD_F00D, "R7 second seed restored", c_push, 32'h0BAD_F00D);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule